// File: doc/BRIEF.md
# Manchester Encoder with Sync Preamble

This block turns a serial NRZ bit stream into a pair of complementary Manchester II line outputs. All its timing comes from one system clock. A speed-select input picks the bit period as 16 or 32 system clocks. A free-running bit-rate strobe, `bit_clk`, tells the upstream data source when to present each bit. The source changes its bit just after `bit_clk` falls, and the encoder samples on that same falling edge.

Transmission is gated by an active-high hold input. While hold is high, both lines rest high and `bit_clk` is held low. When hold goes low, the block waits for the next bit boundary and then sends a fixed preamble of eight Manchester zeros. A three-bit-wide command sync pulse follows, which is not valid Manchester code. Data bits then stream out with no framing or parity until hold is raised again. The length of a block is set only by how long hold stays low.

Top module: `mancode_tx`

## Requirements
- R1: When `hold_tx` is high at a clock edge, `line_pos` and `line_neg` are both 1 and `bit_clk` is 0 after that edge, and they stay so while `hold_tx` stays high.
- R2: A low `rst_n` at a clock edge (synchronous reset) forces both lines to 1 and `bit_clk` to 0 after that edge, and returns the encoder to its idle state.
- R3: The bit period is 16 system clocks when `rate_sel` is 0 and 32 system clocks when `rate_sel` is 1. Each bit is split into two halves of equal length.
- R4: While `hold_tx` is low, `bit_clk` runs continuously. It is 1 in the first half and 0 in the second half of every bit period.
- R5: After `hold_tx` falls, both lines stay 1 until the next bit boundary. Eight preamble bits then follow, each a Manchester zero: `line_pos` is 0 in the first half and 1 in the second half.
- R6: The next three bit periods carry the sync pulse. `line_pos` is 1 for the first 1.5 bit periods and 0 for the last 1.5 bit periods.
- R7: `nrz_in` is sampled at the clock edge where `bit_clk` falls. The first sample is taken in the third sync bit. A bit sampled in bit period k is sent in bit period k+1.
- R8: A data bit of 1 is sent as `line_pos` = 1 then 0. A data bit of 0 is sent as `line_pos` = 0 then 1. `line_pos` therefore changes at every data mid-bit.
- R9: From the first preamble bit onward, `line_neg` is the inverse of `line_pos`.
- R10: Data bits follow one another with no gap, marker or parity bit for as long as `hold_tx` stays low.
- R11: Raising `hold_tx` in the middle of a bit idles the outputs after the next clock edge. Lowering it again starts a complete new preamble and sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_tx | input | 1 | High holds the line idle; a fall starts a new block |
| rate_sel | input | 1 | 0: bit = 16 clocks, 1: bit = 32 clocks (change only while idle) |
| nrz_in | input | 1 | Serial NRZ data, sampled where bit_clk falls |
| bit_clk | output | 1 | 1X bit-rate strobe for the data source |
| line_pos | output | 1 | Manchester output, true polarity |
| line_neg | output | 1 | Manchester output, complement |

## Verification
The assertions check several properties on every cycle. Hold forces the idle line state after the next edge. Each data sample lands exactly where `bit_clk` falls. `line_pos` flips at every data mid-bit. The preamble index never passes its last bit, and the sync pulse always begins at a bit boundary. The exact waveform needs the bench's scenarios: eight zeros, then the 1.5/1.5 sync shape, then the one-bit delay from sample to line. The same holds for the two divisor periods, for restarting after an abort or a reset, and for long unbroken data runs.

// File: rtl/mtx_pkg.sv
// Shared types for the Manchester transmit path.
// Assumes: a single clock domain for every user of this package.
package mtx_pkg;

    // Sequencer phases, from idle through preamble and sync into data.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_PRE  = 3'd2,
        ST_SYNC = 3'd3,
        ST_DATA = 3'd4
    } seq_state_t;

endpackage

// File: rtl/mtx_timebase.sv
// Free-running bit timer. It derives the bit and half-bit timing from the
// system clock, with the divisor chosen by rate_sel.
// Assumes: both divisors are even, and rate_sel changes only while the
// encoder is idle.
module mtx_timebase #(
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    output logic first_half,
    output logic bit_end,
    output logic mid_edge
);
    localparam int TW = $clog2(DIV_SLOW);
    localparam logic [TW-1:0] FAST_LAST = TW'(DIV_FAST - 1);
    localparam logic [TW-1:0] SLOW_LAST = TW'(DIV_SLOW - 1);
    localparam logic [TW-1:0] FAST_HALF = TW'(DIV_FAST / 2);
    localparam logic [TW-1:0] SLOW_HALF = TW'(DIV_SLOW / 2);

    logic [TW-1:0] tick;
    logic [TW-1:0] last_tick;
    logic [TW-1:0] half_pt;

    // Pick the bit length and the half-bit point for the selected rate.
    always_comb begin
        last_tick = rate_sel ? SLOW_LAST : FAST_LAST;
        half_pt   = rate_sel ? SLOW_HALF : FAST_HALF;
    end

    assign bit_end    = (tick >= last_tick);
    assign first_half = (tick < half_pt);
    assign mid_edge   = (tick == half_pt - TW'(1));

    // Count system clocks inside one bit period and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (bit_end) begin
            tick <= '0;
        end else begin
            tick <= tick + TW'(1);
        end
    end

    AST_BOUNDARY_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> first_half); // R4

endmodule

// File: rtl/mtx_sequencer.sv
// Block sequencer. It arms on a low hold, aligns to a bit boundary, then
// walks through the preamble bits, the three sync bits and open-ended data.
// Assumes: bit_end is a one-cycle pulse on the last clock of each bit.
module mtx_sequencer
    import mtx_pkg::*;
#(
    parameter int PRE_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_tx,
    input  logic       bit_end,
    output seq_state_t state,
    output logic [((PRE_BITS > 4) ? $clog2(PRE_BITS) : 2)-1:0] idx
);
    localparam int IW = (PRE_BITS > 4) ? $clog2(PRE_BITS) : 2;
    localparam logic [IW-1:0] PRE_LAST  = IW'(PRE_BITS - 1);
    localparam logic [IW-1:0] SYNC_LAST = IW'(2);

    // Advance through the phases at bit boundaries; a high hold aborts.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_tx) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state <= ST_WAIT;
                    idx   <= '0;
                end
                ST_WAIT: if (bit_end) begin
                    state <= ST_PRE;
                    idx   <= '0;
                end
                ST_PRE: if (bit_end) begin
                    if (idx == PRE_LAST) begin
                        state <= ST_SYNC;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                ST_SYNC: if (bit_end) begin
                    if (idx == SYNC_LAST) begin
                        state <= ST_DATA;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                default: begin
                    state <= state;
                    idx   <= idx;
                end
            endcase
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> (idx <= PRE_LAST)); // R5
    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && $past(state) == ST_PRE) |-> (idx == '0 && $past(bit_end))); // R6

endmodule

// File: rtl/mancode_tx.sv
// Manchester transmitter top. It combines the bit timer and the sequencer,
// holds the sampled NRZ bit for one bit period, and shapes the two line
// outputs and the 1X bit strobe.
// Assumes: rate_sel is changed only while hold_tx is high.
module mancode_tx
    import mtx_pkg::*;
#(
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 32,
    parameter int PRE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_tx,
    input  logic rate_sel,
    input  logic nrz_in,
    output logic bit_clk,
    output logic line_pos,
    output logic line_neg
);
    localparam int IW = (PRE_BITS > 4) ? $clog2(PRE_BITS) : 2;

    logic          first_half;
    logic          bit_end;
    logic          mid_edge;
    seq_state_t    state;
    logic [IW-1:0] idx;
    logic          cap_en;
    logic          cap_q;
    logic          tx_q;
    logic          pos;
    logic          sending;

    mtx_timebase #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) i_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .first_half (first_half),
        .bit_end    (bit_end),
        .mid_edge   (mid_edge)
    );

    mtx_sequencer #(
        .PRE_BITS (PRE_BITS)
    ) i_sequencer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_tx (hold_tx),
        .bit_end (bit_end),
        .state   (state),
        .idx     (idx)
    );

    // Sample only from the last sync bit onward, at the strobe's falling edge.
    assign cap_en = mid_edge &&
                    ((state == ST_SYNC && idx == IW'(2)) || state == ST_DATA);

    // Capture the NRZ bit at mid-bit; move it to the line at the bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            tx_q  <= 1'b0;
        end else begin
            if (cap_en) begin
                cap_q <= nrz_in;
            end
            if (bit_end) begin
                tx_q <= cap_q;
            end
        end
    end

    // Shape the true-polarity line level for the current phase and half-bit.
    always_comb begin
        pos     = 1'b1;
        sending = 1'b0;
        case (state)
            ST_PRE: begin
                sending = 1'b1;
                pos     = ~first_half;
            end
            ST_SYNC: begin
                sending = 1'b1;
                if (idx == IW'(0)) begin
                    pos = 1'b1;
                end else if (idx == IW'(1)) begin
                    pos = first_half;
                end else begin
                    pos = 1'b0;
                end
            end
            ST_DATA: begin
                sending = 1'b1;
                pos     = first_half ? tx_q : ~tx_q;
            end
            default: begin
                pos     = 1'b1;
                sending = 1'b0;
            end
        endcase
    end

    assign line_pos = pos;
    assign line_neg = sending ? ~pos : 1'b1;
    assign bit_clk  = (state != ST_IDLE) && first_half;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_tx |=> (line_pos && line_neg && !bit_clk)); // R1
    AST_CAPTURE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> $fell(bit_clk)); // R7
    AST_DATA_MID_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && mid_edge && !hold_tx) |=> (line_pos != $past(line_pos))); // R8

endmodule

// File: tb/test_mancode_tx.sv
module test_mancode_tx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_tx = 1'b1;
    logic rate_sel = 1'b0;
    logic nrz_in = 1'b0;
    logic bit_clk;
    logic line_pos;
    logic line_neg;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mancode_tx i_mancode_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_tx  (hold_tx),
        .rate_sel (rate_sel),
        .nrz_in   (nrz_in),
        .bit_clk  (bit_clk),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_pos(input int b, input int h, input logic [63:0] pat);
        if (b < 8)   return (h == 1);
        if (b == 8)  return 1'b1;
        if (b == 9)  return (h == 0);
        if (b == 10) return 1'b0;
        return (h == 0) ? pat[b-11] : ~pat[b-11];
    endfunction

    // R2: reset state, both at start-up and in the middle of a block
    task automatic t_reset();
        rst_n = 1'b0;
        hold_tx = 1'b1;
        repeat (3) @(negedge clk);
        chk(line_pos && line_neg && !bit_clk, "R2", "idle lines under reset",
            {line_pos, line_neg, bit_clk}, 3'b110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_pos && line_neg && !bit_clk, "R2", "idle after release",
            {line_pos, line_neg, bit_clk}, 3'b110);
    endtask

    // R1: hold high keeps the line idle for several bit periods
    task automatic t_hold(input int ncyc);
        bit ok = 1'b1;
        hold_tx = 1'b1;
        @(negedge clk);
        for (int i = 0; i < ncyc; i++) begin
            if (!(line_pos && line_neg && !bit_clk)) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R1", "lines high and bit_clk low while held",
            {line_pos, line_neg, bit_clk}, 3'b110);
    endtask

    // R3/R4: bit_clk period and high time for the selected rate
    task automatic t_period(input bit rs);
        int d = rs ? 32 : 16;
        int per = 0;
        int hi = 0;
        int guard = 0;
        bit prev;
        hold_tx = 1'b1;
        rate_sel = rs;
        repeat (2) @(negedge clk);
        hold_tx = 1'b0;
        @(negedge clk);
        prev = bit_clk;
        while (!(bit_clk && !prev) && guard < 200) begin
            prev = bit_clk; @(negedge clk); guard++;
        end
        prev = bit_clk;
        do begin
            if (bit_clk) hi++;
            per++;
            prev = bit_clk;
            @(negedge clk);
        end while (!(bit_clk && !prev) && per < 200);
        chk(per == d, "R3", $sformatf("bit period rate_sel=%0d", rs), per, d);
        chk(hi == d / 2, "R4", $sformatf("bit_clk high time rate_sel=%0d", rs), hi, d / 2);
        hold_tx = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // R5..R10: full block decode; leaves hold_tx low in mid-bit of the last bit
    task automatic t_run(input bit rs, input int nbits, input logic [63:0] pat);
        int d = rs ? 32 : 16;
        int hh = d / 2;
        int guard = 0;
        bit ep;
        string req;
        rate_sel = rs;
        nrz_in = pat[0];
        @(negedge clk);
        hold_tx = 1'b0;
        @(negedge clk);
        chk(line_pos && line_neg, "R5", "lines idle before first boundary",
            {line_pos, line_neg}, 2'b11);
        while (line_pos && guard < 3 * d) begin
            @(negedge clk); guard++;
        end
        chk(!line_pos, "R5", "preamble start seen", line_pos, 0);
        repeat (hh / 2) @(negedge clk);
        for (int b = 0; b < 11 + nbits; b++) begin
            for (int h = 0; h < 2; h++) begin
                ep = exp_pos(b, h, pat);
                req = (b < 8) ? "R5" : ((b < 11) ? "R6" : "R8/R7/R10");
                chk(line_pos == ep, req, $sformatf("line_pos bit %0d half %0d", b, h),
                    line_pos, ep);
                chk(line_neg == !ep, "R9", $sformatf("line_neg bit %0d half %0d", b, h),
                    line_neg, !ep);
                chk(bit_clk == (h == 0), "R4", $sformatf("bit_clk bit %0d half %0d", b, h),
                    bit_clk, (h == 0));
                if (h == 1 && b >= 10 && (b - 9) < 64) nrz_in = pat[b-9];
                repeat (hh) @(negedge clk);
            end
        end
    endtask

    // R11: raise hold mid-bit, expect idle on the next clock
    task automatic t_abort();
        hold_tx = 1'b1;
        @(negedge clk);
        chk(line_pos && line_neg && !bit_clk, "R11", "idle one clock after abort",
            {line_pos, line_neg, bit_clk}, 3'b110);
    endtask

    initial begin
        t_reset();
        t_hold(40);
        t_period(1'b0);
        t_period(1'b1);
        t_run(1'b0, 16, 64'h0000_0000_0000_B4D2);
        t_abort();
        t_hold(20);
        t_run(1'b0, 40, 64'h0000_00C3_A55A_0FF1); // R10 long run, R11 restart
        t_abort();
        t_run(1'b1, 12, 64'h0000_0000_0000_0E93); // R3 slow rate
        // R2: reset in the middle of data
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(line_pos && line_neg && !bit_clk, "R2", "reset mid-block idles",
            {line_pos, line_neg, bit_clk}, 3'b110);
        hold_tx = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        t_hold(10);
        t_run(1'b0, 8, 64'h0000_0000_0000_00FF);
        t_abort();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule